// File: doc/BRIEF.md
# Prioritized CPU Interrupt Level Encoder

This block collects eight level-held interrupt request lines from peripherals into a pending register. From that register it reports one 3-bit priority level and one 8-bit autovector number to a processor. The highest-numbered pending request always wins. A request stays pending only while its source keeps the line active. One of the inputs can be shared by several sources, and this block merges them.

The processor runs an acknowledge cycle by pulsing a strobe together with the level it is servicing. In the same cycle the block answers with a valid pulse and a vector. If the level being acknowledged is no longer the winning level, the vector is the spurious code instead. An acknowledge never removes a request.

Top module: `irq_level_encoder`

## Requirements
- R1: Each of the eight request lines (index 0 to 7) drives one pending bit. On every rising clock edge that bit takes the current level of its line, so it is set while the line is high and clear once the line is low.
- R2: Line index 3 is the OR of `req_line[3]` and every bit of `shared_req`. Either shared source alone makes index 3 pending.
- R3: The highest-numbered pending index i wins. `ipl` is i+1, saturated at 7, so indexes 6 and 7 both give level 7.
- R4: `vec` is i+25 for the winning index i. Index 0 gives 25 and index 7 gives 32.
- R5: With nothing pending, `ipl` and `vec` are both 0.
- R6: `ipl` and `vec` follow an input change after exactly one rising clock edge, and they hold their old values until that edge.
- R7: Synchronous active-high `rst` clears the pending register, so `ipl` and `vec` are 0 after a reset edge.
- R8: While `ack_stb` is high, `ack_valid` is high in the same cycle, and it is low otherwise. If `ack_lvl` equals the current nonzero `ipl`, `ack_vec` equals the current `vec`.
- R9: If `ack_stb` is high and `ack_lvl` is 0 or differs from the current `ipl`, `ack_vec` is the spurious code 24.
- R10: An acknowledge clears no pending bit, so `ipl` and `vec` are unchanged after an acknowledge while the lines stay the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req_line | input | 8 | Level-held request lines, index 7 is the highest priority |
| shared_req | input | 2 | Extra sources ORed into line index 3 |
| ack_stb | input | 1 | Interrupt-acknowledge strobe |
| ack_lvl | input | 3 | Level being acknowledged |
| ipl | output | 3 | Priority level to the processor, 0 when idle |
| vec | output | 8 | Autovector number of the winner, 0 when idle |
| ack_valid | output | 1 | Acknowledge answer valid, same cycle as the strobe |
| ack_vec | output | 8 | Vector returned to the acknowledge |

## Verification
The hardest case to produce is an acknowledge that races a withdrawn request. The processor strobes a level that was the winner one edge earlier, but its source has since dropped the line, so the answer must be the spurious code. The bench reaches this case by asserting a high line and then releasing it. It then strobes the old level once the next edge has moved `ipl` down. A second stimulus drives index 3 only through the shared sources while its own line stays low, and then holds the acknowledge strobe across an edge to show that the pending level survives it.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned NUM_LINES  = 8;
  localparam int unsigned LVL_W      = 3;
  localparam int unsigned VEC_W      = 8;
  localparam int unsigned LVL_MAX    = (1 << LVL_W) - 1;
  localparam int unsigned VEC_OFFSET = 25;
  localparam logic [VEC_W-1:0] VEC_SPURIOUS = 8'd24;
endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
  parameter int unsigned N          = 8,
  parameter int unsigned SHARED_N   = 2,
  parameter int unsigned SHARED_IDX = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        lines,
  input  logic [SHARED_N-1:0] shared,
  output logic [N-1:0]        pend_q
);
  logic [N-1:0] merged;

  for (genvar i = 0; i < N; i++) begin : g_merge
    if (i == SHARED_IDX) begin : g_shared
      assign merged[i] = lines[i] | (|shared);
    end else begin : g_plain
      assign merged[i] = lines[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= merged;
  end
endmodule

// File: rtl/irq_prio_scan.sv
module irq_prio_scan
  import irq_prio_pkg::*;
#(
  parameter int unsigned N = NUM_LINES
) (
  input  logic [N-1:0]       pend,
  output logic [LVL_W-1:0]   lvl,
  output logic [VEC_W-1:0]   vec
);
  logic [N-1:0] above;
  logic [N-1:0] hit;

  assign above[N-1] = 1'b0;
  for (genvar i = N - 1; i > 0; i--) begin : g_chain
    assign above[i-1] = above[i] | pend[i];
  end
  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = pend[i] & ~above[i];
  end

  always_comb begin
    lvl = '0;
    vec = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) begin
        lvl = (i + 1 > LVL_MAX) ? LVL_W'(LVL_MAX) : LVL_W'(i + 1);
        vec = VEC_W'(i + VEC_OFFSET);
      end
    end
  end
endmodule

// File: rtl/irq_ack_resp.sv
module irq_ack_resp
  import irq_prio_pkg::*;
(
  input  logic             ack_stb,
  input  logic [LVL_W-1:0] ack_lvl,
  input  logic [LVL_W-1:0] cur_lvl,
  input  logic [VEC_W-1:0] cur_vec,
  output logic             ack_valid,
  output logic [VEC_W-1:0] ack_vec
);
  logic match;

  assign match     = (ack_lvl == cur_lvl) && (cur_lvl != '0);
  assign ack_valid = ack_stb;
  assign ack_vec   = match ? cur_vec : VEC_SPURIOUS;
endmodule

// File: rtl/irq_level_encoder.sv
module irq_level_encoder
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       req_line,
  input  logic [1:0]       shared_req,
  input  logic             ack_stb,
  input  logic [2:0]       ack_lvl,
  output logic [2:0]       ipl,
  output logic [7:0]       vec,
  output logic             ack_valid,
  output logic [7:0]       ack_vec
);
  logic [NUM_LINES-1:0] pend_q;

  irq_req_capture #(
    .N(NUM_LINES), .SHARED_N(2), .SHARED_IDX(3)
  ) u_capture (
    .clk(clk), .rst(rst), .lines(req_line), .shared(shared_req), .pend_q(pend_q)
  );

  irq_prio_scan #(.N(NUM_LINES)) u_scan (
    .pend(pend_q), .lvl(ipl), .vec(vec)
  );

  irq_ack_resp u_ack (
    .ack_stb(ack_stb), .ack_lvl(ack_lvl), .cur_lvl(ipl), .cur_vec(vec),
    .ack_valid(ack_valid), .ack_vec(ack_vec)
  );
endmodule

// File: rtl/irq_level_encoder_chk.sv
module irq_level_encoder_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] req_line,
  input logic [1:0] shared_req,
  input logic       ack_stb,
  input logic [2:0] ack_lvl,
  input logic [2:0] ipl,
  input logic [7:0] vec,
  input logic       ack_valid,
  input logic [7:0] ack_vec
);
  logic any_req;
  assign any_req = (|req_line) | (|shared_req);

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !any_req |=> (ipl == 3'd0 && vec == 8'd0));

  assert_busy_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    any_req |=> (ipl != 3'd0));

  assert_top_line_R3: assert property (@(posedge clk) disable iff (rst)
    req_line[7] |=> (ipl == 3'd7 && vec == 8'd32));

  assert_shared_R2: assert property (@(posedge clk) disable iff (rst)
    ((|shared_req) && req_line[7:4] == 4'd0) |=> (vec == 8'd28 && ipl == 3'd4));

  assert_vec_pair_R4: assert property (@(posedge clk) disable iff (rst)
    (ipl != 3'd0 && ipl != 3'd7) |-> (vec == 8'd24 + {5'd0, ipl}));

  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (ipl == 3'd0 && vec == 8'd0));

  assert_ack_valid_R8: assert property (@(posedge clk) disable iff (rst)
    ack_valid == ack_stb);

  assert_ack_match_R8: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && ack_lvl == ipl && ipl != 3'd0) |-> (ack_vec == vec));

  assert_ack_spurious_R9: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && (ack_lvl != ipl || ipl == 3'd0)) |-> (ack_vec == 8'd24));

  assert_ack_keeps_R10: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && $stable(req_line) && $stable(shared_req) && ipl != 3'd0)
      |=> $stable(ipl));
endmodule

bind irq_level_encoder irq_level_encoder_chk u_chk (.*);

// File: tb/irq_level_encoder_tb.sv
module irq_level_encoder_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] req_line;
  logic [1:0] shared_req;
  logic       ack_stb;
  logic [2:0] ack_lvl;
  logic [2:0] ipl;
  logic [7:0] vec;
  logic       ack_valid;
  logic [7:0] ack_vec;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irq_level_encoder u_dut (
    .clk(clk), .rst(rst), .req_line(req_line), .shared_req(shared_req),
    .ack_stb(ack_stb), .ack_lvl(ack_lvl), .ipl(ipl), .vec(vec),
    .ack_valid(ack_valid), .ack_vec(ack_vec)
  );

  function automatic logic [2:0] exp_lvl(input logic [7:0] m);
    for (int i = 7; i >= 0; i--) if (m[i]) return (i >= 6) ? 3'd7 : 3'(i + 1);
    return 3'd0;
  endfunction

  function automatic logic [7:0] exp_vec(input logic [7:0] m);
    for (int i = 7; i >= 0; i--) if (m[i]) return 8'(i + 25);
    return 8'd0;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at negedge, cross one posedge, sample at following negedge
  task automatic apply(input logic [7:0] l, input logic [1:0] s);
    req_line = l; shared_req = s;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; req_line = 8'hFF; shared_req = 2'b11; ack_stb = 0; ack_lvl = 0;
    @(posedge clk); @(negedge clk);
    check("R7 ipl", 16'(ipl), 16'd0);
    check("R7 vec", 16'(vec), 16'd0);
    rst = 1'b0; req_line = 8'h00; shared_req = 2'b00;
    @(posedge clk); @(negedge clk);
    check("R5 idle ipl", 16'(ipl), 16'd0);
    check("R5 idle vec", 16'(vec), 16'd0);
  endtask

  task automatic t_single();
    for (int i = 0; i < 8; i++) begin
      apply(8'(1 << i), 2'b00);
      check("R3 single ipl", 16'(ipl), 16'(exp_lvl(8'(1 << i))));
      check("R4 single vec", 16'(vec), 16'(i + 25));
    end
    apply(8'h00, 2'b00);
    check("R1 release", 16'(vec), 16'd0);
  endtask

  task automatic t_multi();
    logic [7:0] pats [5] = '{8'hFF, 8'h05, 8'h81, 8'h3C, 8'h60};
    foreach (pats[k]) begin
      apply(pats[k], 2'b00);
      check("R3 multi ipl", 16'(ipl), 16'(exp_lvl(pats[k])));
      check("R4 multi vec", 16'(vec), 16'(exp_vec(pats[k])));
    end
    apply(8'h00, 2'b00);
  endtask

  task automatic t_shared();
    apply(8'h00, 2'b01);
    check("R2 shared a", 16'(vec), 16'd28);
    apply(8'h00, 2'b10);
    check("R2 shared b", 16'(ipl), 16'd4);
    apply(8'h04, 2'b10);
    check("R2 shared over 2", 16'(vec), 16'd28);
    apply(8'h00, 2'b00);
    check("R1 shared release", 16'(ipl), 16'd0);
  endtask

  task automatic t_latency();
    req_line = 8'h10; shared_req = 2'b00;
    #1;
    check("R6 hold before edge", 16'(vec), 16'd0);
    @(posedge clk); #1;
    check("R6 after one edge", 16'(vec), 16'd29);
    @(negedge clk);
    apply(8'h00, 2'b00);
  endtask

  task automatic t_ack();
    apply(8'h20, 2'b00);            // index 5 -> level 6, vec 30
    ack_stb = 1; ack_lvl = 3'd6; #1;
    check("R8 valid", 16'(ack_valid), 16'd1);
    check("R8 match vec", 16'(ack_vec), 16'd30);
    ack_lvl = 3'd2; #1;
    check("R9 mismatch", 16'(ack_vec), 16'd24);
    ack_lvl = 3'd0; #1;
    check("R9 level zero", 16'(ack_vec), 16'd24);
    ack_lvl = 3'd6;
    @(posedge clk); @(negedge clk); // strobe held across edge
    check("R10 kept ipl", 16'(ipl), 16'd6);
    check("R10 kept vec", 16'(vec), 16'd30);
    ack_stb = 0; #1;
    check("R8 valid low", 16'(ack_valid), 16'd0);
    // race: winner withdrawn, old level acknowledged
    apply(8'h80, 2'b00);
    apply(8'h02, 2'b00);
    ack_stb = 1; ack_lvl = 3'd7; #1;
    check("R9 withdrawn", 16'(ack_vec), 16'd24);
    ack_lvl = 3'd2; #1;
    check("R8 new winner", 16'(ack_vec), 16'd26);
    ack_stb = 0;
    apply(8'h00, 2'b00);
  endtask

  task automatic t_mid_reset();
    apply(8'hC0, 2'b11);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R7 mid reset", 16'(ipl), 16'd0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 after reset", 16'(vec), 16'd32);
    apply(8'h00, 2'b00);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_shared();
    t_latency();
    t_ack();
    t_mid_reset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule